// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block sits on the controller side of a codec link and feeds it command words. Software places 32-bit commands in a circular ring in memory, then moves a write index forward through a small register port. While the run control is set, the engine compares its own read index with that write index. Whenever they differ, it computes the next slot, reads that word through a single-request memory read port, and presents the word on a valid/ready command stream. The read index moves forward only after the command stream has accepted the word.

The read index has a two-step clearing procedure. In the first step software writes the clear bit, and the engine zeroes the index and reports the bit as set. In the second step software writes zero, which ends the clearing state. While clearing is active no fetch starts. The run bit reads back as set until the fetch that has already started has been handed off, so software can poll it to know when the engine is quiet. An error response from memory halts the engine and raises an error flag. A separate low-power input makes both index registers read all ones.

The state machine has five states. FS_IDLE waits for work. FS_REQ presents the memory read. FS_WAIT waits for the response. FS_SEND holds the command word. FS_HALT is entered after an error. The transitions are:
- FS_IDLE goes to FS_REQ (start) when run is set, clearing is inactive and the indices differ.
- FS_REQ goes to FS_WAIT (accepted) when the memory port is ready.
- FS_WAIT goes to FS_SEND (loaded) on a good response, or to FS_HALT (fault) on an error response.
- FS_SEND goes to FS_IDLE (handed) when the command is accepted, and advances the read index at that point.
- FS_HALT goes to FS_IDLE (recovered) when software clears the error.

Top module: `cmdring_engine`

Register map (`reg_addr`):

| Address | Register | Contents |
|---|---|---|
| 0 | ring base | Ring base address; bits 6:0 always read 0 |
| 1 | size code | Ring depth: 0 = 2 entries, 1 = 16, 2 or 3 = 256 |
| 2 | write index | Software write index |
| 3 | read index | Read index; bit 15 is the clear bit |
| 4 | control | Bit 0 = run, bit 1 = error |

## Requirements
- R1: After reset the control register reads 0, the read index and write index read 0, the size code reads 2, and neither `mem_req_valid` nor `cmd_valid` is asserted.
- R2: The engine fetches the slot at (read index + 1) mod depth from address base + 4 × slot. It sets the read index to that slot when the command stream accepts the word, and it keeps fetching until the read index equals the write index. A request holds its address until it is accepted.
- R3: The size code at address 1 selects the depth: 0 gives 2 entries, 1 gives 16, and 2 or 3 gives 256. Indices wrap modulo the depth, and a write to the write index at address 2 stores the value masked to the depth.
- R4: The ring base at address 0 stores the written value with bits 6:0 forced to zero.
- R5: Writing the read index at address 3 with bit 15 = 1 clears the index, which then reads 0x8000, and no fetch starts. A later write with bit 15 = 0 ends the clearing state; the register then reads the index (0) and fetching may resume.
- R6: Control bit 0 (run) reads 1 after software writes 0 for as long as a started fetch has not been handed off, then reads 0. No new fetch starts while run is clear.
- R7: At most one memory read is outstanding: `mem_req_valid` is low from request acceptance until the response arrives.
- R8: An error response halts the engine. Control bit 1 reads 1, the read index does not advance and no command is emitted. Writing control with bit 1 = 1 clears the error, and fetching resumes from the same slot.
- R9: `cmd_codec` equals bits 31:28 of `cmd_data`, and `cmd_data` stays stable while `cmd_valid` is high and `cmd_ready` is low.
- R10: While `low_power` is high, the write index and read index registers read 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_power | input | 1 | Controller is in a powered-down state |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the slot |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_data | input | 32 | Response word |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Link accepts the command |
| cmd_data | output | 32 | Command word |
| cmd_codec | output | 4 | Codec address field of the command |

## Verification
The fetch path is swept over all three depth codes. Each depth gets a single-entry batch and a batch that fills all but one slot across the wrap point, so an error in slot arithmetic or masking shows up as a wrong word in a known position. Back-pressure on the command stream is combined with clearing run, which separates "run reads as requested" from "run reads as busy". An injected memory error and a clear phase held during run show whether the read index and the command stream are truly frozen.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_REQ,
        FS_WAIT,
        FS_SEND,
        FS_HALT
    } fetch_state_e;

    localparam logic [2:0] RA_BASE  = 3'd0;
    localparam logic [2:0] RA_SIZE  = 3'd1;
    localparam logic [2:0] RA_WRPTR = 3'd2;
    localparam logic [2:0] RA_RDPTR = 3'd3;
    localparam logic [2:0] RA_CTRL  = 3'd4;

    localparam int PTR_CLR_BIT = 15;
    localparam int CTRL_RUN    = 0;
    localparam int CTRL_ERR    = 1;

    // index mask for a size code; pw is the widest index
    function automatic logic [15:0] ring_mask(input logic [1:0] code, input int pw);
        logic [15:0] full;
        full = 16'((32'd1 << pw) - 1);
        unique case (code)
            2'd0:    return 16'h0001;
            2'd1:    return 16'h000F & full;
            default: return full;
        endcase
    endfunction

endpackage

// File: rtl/cmdring_regs.sv
module cmdring_regs
    import cmdring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PW    = 8,
    parameter int ALIGN = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          low_power,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic [PW-1:0] rd_ptr,
    input  logic          clr_flag,
    input  logic          busy,
    input  logic          err,
    output logic [AW-1:0] base,
    output logic [PW-1:0] mask,
    output logic [PW-1:0] wr_ptr,
    output logic          run_req,
    output logic          clr_set,
    output logic          clr_end,
    output logic          err_clr
);

    logic [1:0]  size_code;
    logic [15:0] mask_full;

    assign mask_full = ring_mask(size_code, PW);
    assign mask      = mask_full[PW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base      <= '0;
            size_code <= 2'd2;
            wr_ptr    <= '0;
            run_req   <= 1'b0;
        end else if (we) begin
            unique case (addr)
                RA_BASE:  base      <= {wdata[AW-1:ALIGN], {ALIGN{1'b0}}};
                RA_SIZE:  size_code <= wdata[1:0];
                RA_WRPTR: wr_ptr    <= wdata[PW-1:0] & mask;
                RA_CTRL:  run_req   <= wdata[CTRL_RUN];
                default:  ;
            endcase
        end
    end

    assign clr_set = we && (addr == RA_RDPTR) &&  wdata[PTR_CLR_BIT];
    assign clr_end = we && (addr == RA_RDPTR) && !wdata[PTR_CLR_BIT];
    assign err_clr = we && (addr == RA_CTRL)  &&  wdata[CTRL_ERR];

    always_comb begin
        unique case (addr)
            RA_BASE:  rdata = 32'(base);
            RA_SIZE:  rdata = {30'b0, size_code};
            RA_WRPTR: rdata = low_power ? 32'h0000_FFFF : 32'(wr_ptr);
            RA_RDPTR: rdata = low_power ? 32'h0000_FFFF :
                              (clr_flag ? 32'h0000_8000 : 32'(rd_ptr));
            RA_CTRL:  rdata = {30'b0, err, run_req | busy};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/cmdring_rdptr.sv
module cmdring_rdptr #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_set,
    input  logic          clr_end,
    input  logic          adv,
    input  logic [PW-1:0] next_idx,
    output logic [PW-1:0] rd_ptr,
    output logic          clr_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            clr_flag <= 1'b0;
        end else if (clr_set) begin
            rd_ptr   <= '0;
            clr_flag <= 1'b1;
        end else begin
            if (clr_end) clr_flag <= 1'b0;
            if (adv && !clr_flag) rd_ptr <= next_idx;
        end
    end

endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch
    import cmdring_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    input  logic          clr_flag,
    input  logic          err_clr,
    input  logic [AW-1:0] base,
    input  logic [PW-1:0] mask,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] next_idx,
    output logic          adv,
    output logic          busy,
    output logic          err,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic          mem_rsp_err,
    input  logic [31:0]   mem_rsp_data,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [31:0]   cmd_data
);

    fetch_state_e state, state_nx;
    logic [31:0]  word_q;

    assign next_idx     = (rd_ptr + PW'(1)) & mask;
    assign mem_req_addr = base + AW'({next_idx, 2'b00});

    always_comb begin
        state_nx = state;
        unique case (state)
            FS_IDLE: if (run_req && !clr_flag && (rd_ptr != wr_ptr)) state_nx = FS_REQ;
            FS_REQ:  if (mem_req_ready) state_nx = FS_WAIT;
            FS_WAIT: if (mem_rsp_valid) state_nx = mem_rsp_err ? FS_HALT : FS_SEND;
            FS_SEND: if (cmd_ready) state_nx = FS_IDLE;
            FS_HALT: if (err_clr) state_nx = FS_IDLE;
            default: state_nx = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= FS_IDLE;
            word_q <= '0;
        end else begin
            state <= state_nx;
            if (state == FS_WAIT && mem_rsp_valid && !mem_rsp_err) word_q <= mem_rsp_data;
        end
    end

    always_comb begin
        mem_req_valid = (state == FS_REQ);
        cmd_valid     = (state == FS_SEND);
        cmd_data      = word_q;
        adv           = (state == FS_SEND) && cmd_ready;
        busy          = (state == FS_REQ) || (state == FS_WAIT) || (state == FS_SEND);
        err           = (state == FS_HALT);
    end

endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine
    import cmdring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PW    = 8,
    parameter int ALIGN = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          low_power,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic          mem_rsp_err,
    input  logic [31:0]   mem_rsp_data,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [31:0]   cmd_data,
    output logic [3:0]    cmd_codec
);

    logic [AW-1:0] ring_base;
    logic [PW-1:0] idx_mask, wr_idx, rd_ptr, next_idx;
    logic          run_req, clr_set, clr_end, err_clr;
    logic          ptr_clr_flag, fetch_adv, fetch_busy, fetch_err;

    cmdring_regs #(.AW(AW), .PW(PW), .ALIGN(ALIGN)) u_regs (
        .clk(clk), .rst_n(rst_n), .low_power(low_power),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .rd_ptr(rd_ptr), .clr_flag(ptr_clr_flag), .busy(fetch_busy), .err(fetch_err),
        .base(ring_base), .mask(idx_mask), .wr_ptr(wr_idx), .run_req(run_req),
        .clr_set(clr_set), .clr_end(clr_end), .err_clr(err_clr)
    );

    cmdring_rdptr #(.PW(PW)) u_rdptr (
        .clk(clk), .rst_n(rst_n), .clr_set(clr_set), .clr_end(clr_end),
        .adv(fetch_adv), .next_idx(next_idx), .rd_ptr(rd_ptr), .clr_flag(ptr_clr_flag)
    );

    cmdring_fetch #(.AW(AW), .PW(PW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .clr_flag(ptr_clr_flag),
        .err_clr(err_clr), .base(ring_base), .mask(idx_mask), .wr_ptr(wr_idx),
        .rd_ptr(rd_ptr), .next_idx(next_idx), .adv(fetch_adv), .busy(fetch_busy),
        .err(fetch_err), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
    );

    assign cmd_codec = cmd_data[31:28];

endmodule

// File: rtl/cmdring_checker.sv
module cmdring_checker #(
    parameter int AW = 32,
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_rsp_valid,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [31:0]   cmd_data,
    input logic          run_req,
    input logic          fetch_busy,
    input logic          fetch_err,
    input logic          ptr_clr_flag,
    input logic [PW-1:0] rd_ptr
);

    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
        else if (mem_rsp_valid) outstanding <= 1'b0;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data))); // R9

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr_flag |-> (rd_ptr == '0)); // R5

    AST_CLEAR_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_clr_flag && !fetch_busy) |=> !mem_req_valid); // R5

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |-> (!cmd_valid && !mem_req_valid)); // R8

    AST_STOPPED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_req && !fetch_busy && !fetch_err) |=> !mem_req_valid); // R6

endmodule

bind cmdring_engine cmdring_checker #(.AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .run_req(run_req), .fetch_busy(fetch_busy),
    .fetch_err(fetch_err), .ptr_clr_flag(ptr_clr_flag), .rd_ptr(rd_ptr)
);

// File: tb/sim_cmdring_engine.sv
module sim_cmdring_engine;

    localparam logic [31:0] BASE = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        low_power = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] mem_rsp_data = 32'd0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_data;
    logic [3:0]  cmd_codec;

    logic        inj_err = 1'b0;
    int          sc_cur = 2;
    int          gcnt = 0;
    int          codec_bad = 0;
    logic [31:0] got [0:511];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    cmdring_engine u0 (
        .clk(clk), .rst_n(rst_n), .low_power(low_power), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .cmd_codec(cmd_codec)
    );

    function automatic logic [31:0] word_of(input int idx, input int sc);
        return {4'((idx * 7) % 16), 4'hA, 8'(sc), 8'h5C, 8'(idx)};
    endfunction

    // memory model: one-cycle response, slot taken from the address
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        mem_rsp_err   <= mem_req_valid && mem_req_ready && inj_err;
        mem_rsp_data  <= word_of(int'(((mem_req_addr - BASE) >> 2) & 32'hFF), sc_cur);
    end

    // command sink
    always @(posedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            got[gcnt % 512] <= cmd_data;
            gcnt <= gcnt + 1;
            if (cmd_codec != cmd_data[31:28]) codec_bad <= codec_bad + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_rd(input int exp);
        logic [31:0] v;
        for (int k = 0; k < 3000; k++) begin
            rd(3'd3, v);
            if (v == 32'(exp)) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int depth, cur, n, g0, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd4, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(3'd3, v); chk(v == 0, "R1 rdidx", v, 0);
        rd(3'd2, v); chk(v == 0, "R1 wridx", v, 0);
        rd(3'd1, v); chk(v == 2, "R1 size", v, 2);
        chk(!mem_req_valid && !cmd_valid, "R1 outputs", {30'b0, mem_req_valid, cmd_valid}, 0);

        // R4 base alignment
        wr(3'd0, 32'h1234_5677);
        rd(3'd0, v); chk(v == 32'h1234_5600, "R4 base", v, 32'h1234_5600);
        wr(3'd0, BASE);

        // R3 write index masking
        wr(3'd1, 1); wr(3'd2, 32'h1FF);
        rd(3'd2, v); chk(v == 32'hF, "R3 mask16", v, 32'hF);
        wr(3'd1, 0); wr(3'd2, 32'h3);
        rd(3'd2, v); chk(v == 32'h1, "R3 mask2", v, 32'h1);

        // R2/R3 sweep over size codes with wrap-around batches
        for (int sc = 0; sc < 3; sc++) begin
            sc_cur = sc;
            depth = (sc == 0) ? 2 : (sc == 1) ? 16 : 256;
            wr(3'd1, 32'(sc));
            wr(3'd3, 32'h8000); wr(3'd3, 0);
            wr(3'd2, 0);
            wr(3'd4, 1);
            cur = 0;
            for (int b = 0; b < 3; b++) begin
                n = (b == 1) ? depth - 1 : 1;
                g0 = gcnt;
                wr(3'd2, 32'((cur + n) % depth));
                wait_rd((cur + n) % depth);
                repeat (2) @(negedge clk);
                chk(gcnt - g0 == n, "R2 count", 32'(gcnt - g0), 32'(n));
                bad = 0;
                for (int j = 0; j < n; j++)
                    if (got[(g0 + j) % 512] != word_of((cur + 1 + j) % depth, sc)) bad++;
                chk(bad == 0, "R3 wrap order", 32'(bad), 0);
                cur = (cur + n) % depth;
                rd(3'd3, v); chk(v == 32'(cur), "R2 rdidx", v, 32'(cur));
            end
            wr(3'd4, 0);
        end
        chk(codec_bad == 0, "R9 codec field", 32'(codec_bad), 0);

        // R6 run clear with a fetch in flight
        sc_cur = 2;
        wr(3'd1, 2); wr(3'd3, 32'h8000); wr(3'd3, 0); wr(3'd2, 0);
        cmd_ready = 1'b0;
        g0 = gcnt;
        wr(3'd2, 3); wr(3'd4, 1);
        for (int k = 0; k < 50 && !cmd_valid; k++) @(negedge clk);
        wr(3'd4, 0);
        repeat (4) @(negedge clk);
        rd(3'd4, v); chk(v[0] == 1'b1, "R6 run busy", v, 1);
        chk(cmd_valid && cmd_data == word_of(1, 2), "R9 hold", cmd_data, word_of(1, 2));
        cmd_ready = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd4, v); chk(v == 0, "R6 run idle", v, 0);
        repeat (20) @(negedge clk);
        rd(3'd3, v); chk(v == 1, "R6 stopped", v, 1);
        chk(gcnt - g0 == 1, "R6 one cmd", 32'(gcnt - g0), 1);

        // R8 memory error halts, clear resumes
        inj_err = 1'b1;
        g0 = gcnt;
        wr(3'd4, 1);
        for (int k = 0; k < 50; k++) begin
            rd(3'd4, v);
            if (v[1]) break;
        end
        inj_err = 1'b0;
        repeat (5) @(negedge clk);
        rd(3'd4, v); chk(v == 3, "R8 err flag", v, 3);
        rd(3'd3, v); chk(v == 1, "R8 idx frozen", v, 1);
        chk(gcnt == g0, "R8 no cmd", 32'(gcnt - g0), 0);
        wr(3'd4, 3);
        wait_rd(3);
        repeat (2) @(negedge clk);
        chk(gcnt - g0 == 2 && got[g0 % 512] == word_of(2, 2), "R8 resume",
            got[g0 % 512], word_of(2, 2));
        rd(3'd4, v); chk(v == 1, "R8 err cleared", v, 1);

        // R5 clear handshake blocks fetching
        wr(3'd4, 0);
        wr(3'd3, 32'h8000);
        rd(3'd3, v); chk(v == 32'h8000, "R5 clear phase", v, 32'h8000);
        g0 = gcnt;
        wr(3'd2, 5); wr(3'd4, 1);
        repeat (20) @(negedge clk);
        chk(gcnt == g0, "R5 no fetch", 32'(gcnt - g0), 0);
        rd(3'd3, v); chk(v == 32'h8000, "R5 still clear", v, 32'h8000);
        wr(3'd3, 0);
        wait_rd(5);
        repeat (2) @(negedge clk);
        chk(gcnt - g0 == 5 && got[g0 % 512] == word_of(1, 2), "R5 resume from 1",
            32'(gcnt - g0), 5);
        wr(3'd4, 0);

        // R10 low power reads
        low_power = 1'b1;
        rd(3'd2, v); chk(v == 32'hFFFF, "R10 wridx", v, 32'hFFFF);
        rd(3'd3, v); chk(v == 32'hFFFF, "R10 rdidx", v, 32'hFFFF);
        low_power = 1'b0;
        rd(3'd3, v); chk(v == 5, "R10 restored", v, 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule